// File: doc/BRIEF.md
# I2C Target Receive Engine with Clock-Stretch Hold

This block is the receive side of an I2C target. It samples the SCL and SDA pins through a synchronizer, recognises Start and Stop conditions, and shifts in a 7-bit address with its direction bit followed by data bytes. It acknowledges a matching write address and every data byte that follows it. Received data lands in an 8-bit buffer with a full flag and a sticky overflow flag. An optional buffer-overwrite mode keeps refreshing the buffer while still reporting overflow.

The block can stretch the clock after the eighth falling SCL edge of an address byte, of a data byte, or both. A status flag marks the acknowledge window so that software knows when a held byte is waiting. Software ends the stretch with a one-cycle release strobe. The SDA output only changes a programmable number of system clocks after SCL has fallen, with a short and a long setting. Start and Stop pulses are gated by their own enables. An optional check flags a collision in the acknowledge slot.

Control arrives as a 7-bit vector held by the surrounding register logic. Bit 0 enables the Start interrupt, bit 1 enables the Stop interrupt, bit 2 enables buffer overwrite, bit 3 enables the address hold, bit 4 enables the data hold, bit 5 selects the long SDA hold and bit 6 enables collision detection.

Top module: `i2c_target_rx`

## Requirements
- R1: After reset, scl_hold_o, sda_drive_o, buf_full_o, ovf_o, ack_time_o and all pulse outputs are 0, and rx_data_o is 8'h00.
- R2: Bytes arrive MSB first. The first byte after a Start is acknowledged (SDA driven low in the ninth clock) only when its upper seven bits equal own_addr_i and its LSB is 0. Any other first byte gets a NACK, and the rest of the transfer up to the next Start leaves the buffer and flags untouched.
- R3: Each data byte of an acknowledged transfer is acknowledged, written to rx_data_o and sets buf_full_o. A rd_buf_i strobe clears buf_full_o.
- R4: sda_drive_o changes exactly HOLD_SHORT+3 system clocks after SCL falls at the pin, or HOLD_LONG+3 when ctrl_i[5] is 1. Three of those clocks are synchronizer and edge-detect latency.
- R5: With ctrl_i[3] set, scl_hold_o goes high after the eighth falling SCL edge of an acknowledged address byte. It stays high until a rel_set_i strobe, and drops in the cycle after that strobe.
- R6: With ctrl_i[4] set, the same hold follows the eighth falling SCL edge of a data byte. An address byte raises no hold when ctrl_i[3] is 0.
- R7: ack_time_o rises on the eighth falling SCL edge of a byte when ctrl_i[3] or ctrl_i[4] is set, and falls on the ninth rising SCL edge. With both bits clear it never rises.
- R8: ovf_o is set when a data byte completes while buf_full_o is 1 and no read happens in that cycle. It stays set until an ovf_clr_i strobe.
- R9: With ctrl_i[2] clear, a data byte that completes while ovf_o is 1 leaves rx_data_o unchanged.
- R10: With ctrl_i[2] set, every completed data byte is written to rx_data_o whatever the state of ovf_o, and overflow is still reported.
- R11: start_irq_o pulses once per Start only when ctrl_i[0] is 1, and stop_irq_o pulses once per Stop only when ctrl_i[1] is 1.
- R12: With ctrl_i[6] set, coll_o pulses when the block releases SDA in an address acknowledge slot and samples SDA low on the ninth rising SCL edge. With ctrl_i[6] clear it never pulses.
- R13: If rd_buf_i is high in the very cycle a data byte completes, the read is taken as happening first. The new byte is stored, buf_full_o stays 1 and ovf_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| own_addr_i | input | 7 | Programmed 7-bit target address |
| ctrl_i | input | 7 | Enable and select bits (see above) |
| rel_set_i | input | 1 | Software clock-release strobe |
| rd_buf_i | input | 1 | Buffer read strobe, clears the full flag |
| ovf_clr_i | input | 1 | Overflow clear strobe |
| scl_hold_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_o | output | 1 | Pull SDA low (acknowledge) |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | Sticky overflow flag |
| ack_time_o | output | 1 | Acknowledge window active |
| start_irq_o | output | 1 | Start interrupt pulse |
| stop_irq_o | output | 1 | Stop interrupt pulse |
| coll_o | output | 1 | Collision pulse |

## Verification
A software read of the buffer and the completion of a new data byte can land in the same system clock. The collision lies in how the full and overflow flags resolve between them. The bench leaves a byte unread, then sends the next byte and raises rd_buf_i for exactly the cycle in which the eighth falling SCL edge reaches the buffer (three clocks after the pin edge). It then expects the new byte to be stored, the full flag to stay set and the overflow flag to stay clear. The same bench also forces the ordinary overflow case, with no read, for comparison.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CTRL_W = 7;

  // control vector bit positions
  localparam int CB_START_IE = 0;
  localparam int CB_STOP_IE  = 1;
  localparam int CB_OVERWR   = 2;
  localparam int CB_AHOLD    = 3;
  localparam int CB_DHOLD    = 4;
  localparam int CB_LONGHOLD = 5;
  localparam int CB_COLL     = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/i2crx_rst_sync.sv
module i2crx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sn = stg_q[1];
endmodule

// File: rtl/i2crx_sync.sv
module i2crx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] d;
    if (s == 0) begin : g_first
      assign d = pin_i;
    end else begin : g_next
      assign d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2crx_hold_timer.sv
module i2crx_hold_timer #(
  parameter int HOLD_SHORT = 10,
  parameter int HOLD_LONG  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  logic val_i,
  input  logic long_i,
  output logic drive_o
);
  localparam int MAXC = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          drv_q, drv_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    drv_d  = drv_q;
    if (ld_i) begin
      cnt_d  = long_i ? CW'(HOLD_LONG) : CW'(HOLD_SHORT);
      pend_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) drv_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      drv_q  <= drv_d;
    end
  end

  assign drive_o = drv_q;
endmodule

// File: rtl/i2crx_buffer.sv
module i2crx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  input  logic         ovf_clr_i,
  input  logic         overwrite_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         ovf_o
);
  logic [W-1:0] data_q, data_d;
  logic         full_q, full_d;
  logic         ovf_q, ovf_d;
  logic         data_en;

  always_comb begin
    data_en = wr_i && (!ovf_q || overwrite_i);
    data_d  = data_en ? wdata_i : data_q;
    full_d  = full_q;
    ovf_d   = ovf_q;
    if (wr_i)      full_d = 1'b1;
    else if (rd_i) full_d = 1'b0;
    if (wr_i && full_q && !rd_i) ovf_d = 1'b1;
    else if (ovf_clr_i)          ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2crx_pkg::*;
#(
  parameter int HOLD_SHORT  = 10,
  parameter int HOLD_LONG   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              rel_set_i,
  input  logic              rd_buf_i,
  input  logic              ovf_clr_i,
  output logic              scl_hold_o,
  output logic              sda_drive_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              ack_time_o,
  output logic              start_irq_o,
  output logic              stop_irq_o,
  output logic              coll_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic rst_sn;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              slot_q, slot_d;
  logic              ackg_q, ackg_d;
  logic              at_q, at_d;
  logic              rel_q, rel_d;
  logic              sirq_q, pirq_q, coll_q, coll_d;
  logic              ld, ld_val, wr_req, hold_req, addr_hit, in_byte;

  i2crx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  i2crx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .pin_i({scl_i, sda_i}),
    .lvl_o({scl_s, sda_s}), .prev_o({scl_p, sda_p})
  );

  assign scl_rise  = !scl_p && scl_s;
  assign scl_fall  = scl_p && !scl_s;
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
  assign addr_hit  = (sh_q[BYTE_W-1:1] == own_addr_i) && !sh_q[0];
  assign in_byte   = (state_q == ST_ADDR) || (state_q == ST_DATA);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    slot_d   = slot_q;
    ackg_d   = ackg_q;
    at_d     = at_q;
    coll_d   = 1'b0;
    ld       = 1'b0;
    ld_val   = 1'b0;
    wr_req   = 1'b0;
    hold_req = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      slot_d  = 1'b0;
      at_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      slot_d  = 1'b0;
      at_d    = 1'b0;
    end else if (in_byte) begin
      if (scl_rise) begin
        if (!slot_q && cnt_q != LAST_BIT) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + CNT_W'(1);
        end else if (slot_q) begin
          at_d   = 1'b0;
          coll_d = ctrl_i[CB_COLL] && !ackg_q && !sda_s;
        end
      end
      if (scl_fall) begin
        if (!slot_q && cnt_q == LAST_BIT) begin
          slot_d   = 1'b1;
          ackg_d   = (state_q == ST_DATA) || addr_hit;
          ld       = 1'b1;
          ld_val   = ackg_d;
          at_d     = ctrl_i[CB_AHOLD] || ctrl_i[CB_DHOLD];
          wr_req   = (state_q == ST_DATA);
          hold_req = ackg_d && ((state_q == ST_ADDR) ? ctrl_i[CB_AHOLD]
                                                     : ctrl_i[CB_DHOLD]);
        end else if (slot_q) begin
          slot_d  = 1'b0;
          cnt_d   = '0;
          ld      = 1'b1;
          ld_val  = 1'b0;
          state_d = ackg_q ? ST_DATA : ST_SKIP;
        end
      end
    end
    if (rel_set_i)     rel_d = 1'b1;
    else if (hold_req) rel_d = 1'b0;
    else               rel_d = rel_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      slot_q  <= 1'b0;
      ackg_q  <= 1'b0;
      at_q    <= 1'b0;
      rel_q   <= 1'b1;
      sirq_q  <= 1'b0;
      pirq_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      slot_q  <= slot_d;
      ackg_q  <= ackg_d;
      at_q    <= at_d;
      rel_q   <= rel_d;
      sirq_q  <= start_det && ctrl_i[CB_START_IE];
      pirq_q  <= stop_det && ctrl_i[CB_STOP_IE];
      coll_q  <= coll_d;
    end
  end

  i2crx_hold_timer #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
    .clk(clk), .rst_n(rst_sn), .ld_i(ld), .val_i(ld_val),
    .long_i(ctrl_i[CB_LONGHOLD]), .drive_o(sda_drive_o)
  );

  i2crx_buffer #(.W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_sn), .wr_i(wr_req), .wdata_i(sh_q),
    .rd_i(rd_buf_i), .ovf_clr_i(ovf_clr_i), .overwrite_i(ctrl_i[CB_OVERWR]),
    .data_o(rx_data_o), .full_o(buf_full_o), .ovf_o(ovf_o)
  );

  assign scl_hold_o  = !rel_q;
  assign ack_time_o  = at_q;
  assign start_irq_o = sirq_q;
  assign stop_irq_o  = pirq_q;
  assign coll_o      = coll_q;
endmodule

// File: rtl/i2crx_checker.sv
module i2crx_checker
  import i2crx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              rel_set_i,
  input logic              ovf_clr_i,
  input logic              scl_hold_o,
  input logic [BYTE_W-1:0] rx_data_o,
  input logic              ovf_o,
  input logic              ack_time_o,
  input logic              start_irq_o,
  input logic              stop_irq_o,
  input logic              coll_o,
  input logic              scl_rise,
  input logic              start_det,
  input logic              stop_det
);
  a_r5_release_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rel_set_i |=> !scl_hold_o);

  a_r6_hold_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_o) |-> $past(ctrl_i[CB_AHOLD] || ctrl_i[CB_DHOLD]));

  a_r7_window_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_time_o) |-> $past(ctrl_i[CB_AHOLD] || ctrl_i[CB_DHOLD]));

  a_r7_window_ends_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_time_o) |-> $past(scl_rise || start_det || stop_det));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ctrl_i[CB_OVERWR]) |=> $stable(rx_data_o));

  a_r11_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq_o |-> $past(ctrl_i[CB_START_IE]));

  a_r11_stop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq_o |-> $past(ctrl_i[CB_STOP_IE]));

  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_irq_o, stop_irq_o}));

  a_r12_coll_gated: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> $past(ctrl_i[CB_COLL]));
endmodule

bind i2c_target_rx i2crx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .rel_set_i(rel_set_i),
  .ovf_clr_i(ovf_clr_i), .scl_hold_o(scl_hold_o), .rx_data_o(rx_data_o),
  .ovf_o(ovf_o), .ack_time_o(ack_time_o), .start_irq_o(start_irq_o),
  .stop_irq_o(stop_irq_o), .coll_o(coll_o), .scl_rise(scl_rise),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sim_i2c_target_rx.sv
`timescale 1ns/1ps
module sim_i2c_target_rx;
  localparam int HS = 10;
  localparam int HL = 30;
  localparam int Q  = 40;
  localparam logic [6:0] OWN = 7'h5A;
  localparam logic [6:0] C_IRQ = 7'b0000011;
  localparam logic [6:0] C_OVW = 7'b0000100;
  localparam logic [6:0] C_AH  = 7'b0001000;
  localparam logic [6:0] C_DH  = 7'b0010000;
  localparam logic [6:0] C_LNG = 7'b0100000;
  localparam logic [6:0] C_COL = 7'b1000000;
  localparam int NV = 6;
  // {address byte, data byte, expected address ack}
  localparam logic [16:0] VEC [NV] = '{
    {8'hB4, 8'h3C, 1'b1}, {8'hB5, 8'h11, 1'b0}, {8'hB6, 8'h22, 1'b0},
    {8'hB4, 8'hFF, 1'b1}, {8'h34, 8'h33, 1'b0}, {8'hB4, 8'h00, 1'b1}};

  logic clk, rst_n;
  logic scl_m, sda_m, sda_oth;
  logic [6:0] ctrl;
  logic rel_set, rd_buf, ovf_clr;
  logic scl_hold, sda_drive, buf_full, ovf, ack_time, s_irq, p_irq, coll;
  logic [7:0] rx_data;
  logic scl_bus, sda_bus;

  int n_chk, n_bad, cyc, t_fall, t_drv, n_start, n_stop, n_coll, n_at, n_hold;
  logic drv_q, done;

  assign scl_bus = scl_m & ~scl_hold;
  assign sda_bus = sda_m & sda_oth & ~sda_drive;

  i2c_target_rx #(.HOLD_SHORT(HS), .HOLD_LONG(HL)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .own_addr_i(OWN), .ctrl_i(ctrl), .rel_set_i(rel_set), .rd_buf_i(rd_buf),
    .ovf_clr_i(ovf_clr), .scl_hold_o(scl_hold), .sda_drive_o(sda_drive),
    .rx_data_o(rx_data), .buf_full_o(buf_full), .ovf_o(ovf),
    .ack_time_o(ack_time), .start_irq_o(s_irq), .stop_irq_o(p_irq),
    .coll_o(coll)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sda_drive && !drv_q) t_drv = cyc;
    drv_q <= sda_drive;
    if (s_irq) n_start++;
    if (p_irq) n_stop++;
    if (coll) n_coll++;
    if (ack_time) n_at++;
    if (scl_hold) n_hold++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic halfq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, input logic rd_sync);
    sda_m = b;
    halfq(Q);
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    halfq(Q);
    scl_m = 1'b0;
    t_fall = cyc;
    if (rd_sync) begin
      halfq(2);
      rd_buf = 1'b1;
      @(negedge clk);
      rd_buf = 1'b0;
      halfq(Q - 3);
    end else begin
      halfq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic oth, input logic rd_sync,
                           output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i], rd_sync && (i == 0));
    sda_m = 1'b1;
    if (oth) sda_oth = 1'b0;
    halfq(Q);
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    halfq(Q);
    ack = ~sda_bus;
    scl_m = 1'b0;
    halfq(Q);
    sda_oth = 1'b1;
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1; halfq(Q);
    sda_m = 1'b0; halfq(Q);
    scl_m = 1'b0; halfq(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; halfq(Q);
    scl_m = 1'b1; halfq(Q);
    sda_m = 1'b1; halfq(Q);
  endtask

  task automatic strobe_rd();
    @(negedge clk) rd_buf = 1'b1;
    @(negedge clk) rd_buf = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
  endtask

  task automatic held_byte(input logic [7:0] b, output logic ack);
    fork
      send_byte(b, 1'b0, 1'b0, ack);
      begin
        wait (scl_hold == 1'b1);
        @(negedge clk);
        chk("R7 window open during hold", int'(ack_time), 1);
        halfq(200);
        chk("R5/R6 SCL still stretched", int'(scl_hold), 1);
        chk("R5/R6 SCL bus low", int'(scl_bus), 0);
        @(negedge clk) rel_set = 1'b1;
        @(negedge clk) rel_set = 1'b0;
        chk("R5/R6 hold dropped after release", int'(scl_hold), 0);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic ack;
    int h0, c0, s0, p0;
    done = 0; n_chk = 0; n_bad = 0; cyc = 0; t_fall = 0; t_drv = 0;
    n_start = 0; n_stop = 0; n_coll = 0; n_at = 0; n_hold = 0; drv_q = 0;
    scl_m = 1; sda_m = 1; sda_oth = 1; ctrl = '0;
    rel_set = 0; rd_buf = 0; ovf_clr = 0;
    rst_n = 0;
    halfq(5);
    rst_n = 1;
    halfq(5);

    // R1 reset state
    chk("R1 scl_hold", int'(scl_hold), 0);
    chk("R1 sda_drive", int'(sda_drive), 0);
    chk("R1 buf_full", int'(buf_full), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 ack_time", int'(ack_time), 0);
    chk("R1 rx_data", int'(rx_data), 0);

    // vector table: R2, R3, R11, R7
    ctrl = C_IRQ;
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ab, db;
      logic ea;
      {ab, db, ea} = VEC[v];
      do_start();
      send_byte(ab, 1'b0, 1'b0, ack);
      chk("R2 address ack", int'(ack), int'(ea));
      send_byte(db, 1'b0, 1'b0, ack);
      chk("R3 data ack", int'(ack), int'(ea));
      do_stop();
      chk("R2/R3 buf_full", int'(buf_full), int'(ea));
      if (ea) chk("R3 rx_data", int'(rx_data), int'(db));
      strobe_rd();
      chk("R3 full cleared by read", int'(buf_full), 0);
    end
    chk("R11 start pulses", n_start, NV);
    chk("R11 stop pulses", n_stop, NV);
    chk("R7 no window without hold enables", n_at, 0);

    // R4 short and long SDA hold
    ctrl = '0;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    chk("R4 short hold delay", t_drv - t_fall, HS + 3);
    do_stop();
    ctrl = C_LNG;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    chk("R4 long hold delay", t_drv - t_fall, HL + 3);
    send_byte(8'h5E, 1'b0, 1'b0, ack);
    chk("R4 long hold data delay", t_drv - t_fall, HL + 3);
    do_stop();
    strobe_rd();

    // R5 address hold, data not held
    ctrl = C_AH;
    do_start();
    held_byte(8'hB4, ack);
    chk("R5 address acked", int'(ack), 1);
    chk("R7 window closed after ninth rise", int'(ack_time), 0);
    h0 = n_hold;
    send_byte(8'hA5, 1'b0, 1'b0, ack);
    chk("R5 no data hold with only address hold", n_hold - h0, 0);
    do_stop();
    chk("R3 rx after address hold", int'(rx_data), 8'hA5);
    strobe_rd();

    // R6 data hold, address not held
    ctrl = C_DH;
    do_start();
    h0 = n_hold;
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    chk("R6 no address hold", n_hold - h0, 0);
    held_byte(8'hC3, ack);
    chk("R6 data acked", int'(ack), 1);
    chk("R7 window closed", int'(ack_time), 0);
    do_stop();
    chk("R6 rx after data hold", int'(rx_data), 8'hC3);
    strobe_rd();

    // R8/R9 overflow without overwrite
    ctrl = '0;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    send_byte(8'h11, 1'b0, 1'b0, ack);
    chk("R8 no ovf on first byte", int'(ovf), 0);
    send_byte(8'h22, 1'b0, 1'b0, ack);
    chk("R8 ovf set", int'(ovf), 1);
    chk("R9 byte stored while ovf was clear", int'(rx_data), 8'h22);
    send_byte(8'h33, 1'b0, 1'b0, ack);
    do_stop();
    chk("R9 buffer kept while ovf set", int'(rx_data), 8'h22);
    chk("R8 ovf sticky", int'(ovf), 1);
    strobe_rd();
    chk("R8 ovf survives read", int'(ovf), 1);
    strobe_clr();
    chk("R8 ovf cleared", int'(ovf), 0);

    // R10 overwrite
    ctrl = C_OVW;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    send_byte(8'h44, 1'b0, 1'b0, ack);
    send_byte(8'h55, 1'b0, 1'b0, ack);
    send_byte(8'h66, 1'b0, 1'b0, ack);
    do_stop();
    chk("R10 latest byte stored", int'(rx_data), 8'h66);
    chk("R10 overflow still reported", int'(ovf), 1);
    strobe_clr();
    strobe_rd();

    // R13 read in the completion cycle
    ctrl = '0;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    send_byte(8'h77, 1'b0, 1'b0, ack);
    chk("R13 setup full", int'(buf_full), 1);
    send_byte(8'h88, 1'b0, 1'b1, ack);
    do_stop();
    chk("R13 new byte stored", int'(rx_data), 8'h88);
    chk("R13 full stays set", int'(buf_full), 1);
    chk("R13 no overflow", int'(ovf), 0);
    strobe_rd();

    // R11 interrupts disabled
    s0 = n_start; p0 = n_stop;
    do_start();
    send_byte(8'hB4, 1'b0, 1'b0, ack);
    do_stop();
    chk("R11 no start pulse when disabled", n_start - s0, 0);
    chk("R11 no stop pulse when disabled", n_stop - p0, 0);

    // R12 collision in address ack slot
    ctrl = C_COL;
    c0 = n_coll;
    do_start();
    send_byte(8'h20, 1'b1, 1'b0, ack);
    do_stop();
    chk("R12 collision flagged", n_coll - c0, 1);
    ctrl = '0;
    c0 = n_coll;
    do_start();
    send_byte(8'h20, 1'b1, 1'b0, ack);
    do_stop();
    chk("R12 no collision when disabled", n_coll - c0, 0);
    chk("R2 mismatch leaves buffer empty", int'(buf_full), 0);

    done = 1;
    summary();
  end
endmodule